// File: doc/BRIEF.md
# Shadow Return-Stack Checker

This block keeps a private copy of the return addresses seen by instrumented code and uses it to judge every return. The instrumented side sends a stream of typed events. A call event carries the return address that the call has just placed on the monitored stack. A return event carries the address that the code is about to return to. The checker pushes the address of each call onto its own stack. On each return it takes the newest entry off that stack and compares it with the reported address. The monitored processor cannot reach this storage, so a corrupted return address on the real stack shows up as a disagreement between the two.

Any disagreement raises a fault, and so do a return with nothing stacked and a call that finds the stack already full. Each fault kind has its own flag. The flags stay set until reset, and their OR forms a single alert. The block also gives a one-cycle pulse for each offending event and reports the current stack occupancy. The block accepts one event in every clock cycle and never stalls. What carries the events to the block, and what the system does once the alert is raised, are left to the surrounding logic.

Top module: `scs_top`

## Requirements
- R1: After reset, `stackDepth` is 0 and `alert`, `overflowFault`, `underflowFault`, `mismatchFault` and `violPulse` are all 0.
- R2: An event sampled with `evtValid`=1 and `evtKind`=0 is a call. When fewer than DEPTH (default 32) entries are held, the call stores `evtAddr` as the new top entry, and `stackDepth` rises by one after that clock edge.
- R3: An event sampled with `evtValid`=1 and `evtKind`=1 is a return. When at least one entry is held, the return removes the top entry and `stackDepth` falls by one. If `evtAddr` equals the removed entry, no fault is raised.
- R4: A return on a non-empty stack whose `evtAddr` differs from the top entry sets `mismatchFault`. The entry is still consumed, so the following return is compared with the entry below it.
- R5: A return when `stackDepth` is 0 sets `underflowFault`, and `stackDepth` stays 0.
- R6: A call when `stackDepth` equals DEPTH sets `overflowFault`. Its address is discarded, `stackDepth` stays at DEPTH, and the entries already held are left intact.
- R7: `overflowFault`, `underflowFault`, `mismatchFault` and `alert` stay at 1 until the next reset, whatever events follow. Reset clears them.
- R8: `alert` is the OR of the three fault flags. `violPulse` is 1 for exactly the one cycle after each offending event (overflow, underflow or mismatch) and is 0 after every other cycle.
- R9: While `evtValid` is 0, `evtKind` and `evtAddr` have no effect: `stackDepth` and all flags hold their values.
- R10: Every event completes in the cycle it is sampled. Events on consecutive cycles are each applied, and all outputs reflect an event right after the clock edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | An event is present this cycle |
| evtKind | input | 1 | 0 = call, 1 = return |
| evtAddr | input | ADDR_W | Return address carried by the event |
| stackDepth | output | $clog2(DEPTH+1) | Number of entries held |
| alert | output | 1 | OR of the sticky fault flags |
| overflowFault | output | 1 | Sticky: call made on a full stack |
| underflowFault | output | 1 | Sticky: return made on an empty stack |
| mismatchFault | output | 1 | Sticky: return address differed from the top entry |
| violPulse | output | 1 | One-cycle pulse after each offending event |

## Verification
A mismatching return both raises a fault and pops the stack in the same cycle, so a design that flags the fault but skips the pop is caught. The bench sweeps every depth from 1 to DEPTH. At each depth it sends a return with a corrupted address and checks that the depth fell by one. It then sends a correct return for the entry below and checks that `violPulse` stays low for that return. An overflowing call likewise sets its flag and leaves the stack untouched in the same cycle. This is judged by unwinding the full stack afterwards and confirming that every stored address still matches.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic {
    EV_CALL = 1'b0,
    EV_RET  = 1'b1
  } evKind_t;

  // strobes from control to datapath, all valid in the cycle of the event
  typedef struct packed {
    logic push;    // write the event address as the new top
    logic chkTop;  // compare the event address with the current top
    logic setOvf;  // call rejected on a full stack
    logic setUnf;  // return on an empty stack
  } stackCtl_t;

endpackage

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  evKind_t          evtKind,
  output stackCtl_t        ctl,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] depth
);

  logic isFull;
  logic isEmpty;
  logic isCall;
  logic isRet;

  assign isFull  = (depth == CNT_W'(DEPTH));
  assign isEmpty = (depth == '0);
  assign isCall  = evtValid && (evtKind == EV_CALL);
  assign isRet   = evtValid && (evtKind == EV_RET);

  always_comb begin
    ctl        = '0;
    ctl.push   = isCall && !isFull;
    ctl.setOvf = isCall && isFull;
    ctl.chkTop = isRet && !isEmpty;
    ctl.setUnf = isRet && isEmpty;
  end

  // the free slot sits at index depth, the top entry at depth-1
  assign wrIdx = IDX_W'(depth);
  assign rdIdx = IDX_W'(depth - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (ctl.push) begin
      depth <= depth + CNT_W'(1);
    end else if (ctl.chkTop) begin
      depth <= depth - CNT_W'(1);
    end
  end

endmodule

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCtl_t         ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              ovfFlag,
  output logic              unfFlag,
  output logic              mmFlag,
  output logic              violFlag
);

  logic [ADDR_W-1:0] shadowMem [DEPTH];
  logic              topDiffers;
  logic              badReturn;

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      shadowMem[wrIdx] <= addrIn;
    end
  end

  assign topDiffers = (shadowMem[rdIdx] != addrIn);
  assign badReturn  = ctl.chkTop && topDiffers;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      unfFlag  <= 1'b0;
      mmFlag   <= 1'b0;
      violFlag <= 1'b0;
    end else begin
      ovfFlag  <= ovfFlag | ctl.setOvf;
      unfFlag  <= unfFlag | ctl.setUnf;
      mmFlag   <= mmFlag | badReturn;
      violFlag <= ctl.setOvf | ctl.setUnf | badReturn;
    end
  end

endmodule

// File: rtl/scs_top.sv
module scs_top
  import scs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic              evtKind,
  input  logic [ADDR_W-1:0] evtAddr,
  output logic [CNT_W-1:0]  stackDepth,
  output logic              alert,
  output logic              overflowFault,
  output logic              underflowFault,
  output logic              mismatchFault,
  output logic              violPulse
);

  stackCtl_t        ctl;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  scs_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .evtKind  (evKind_t'(evtKind)),
    .ctl      (ctl),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx),
    .depth    (stackDepth)
  );

  scs_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx),
    .addrIn   (evtAddr),
    .ovfFlag  (overflowFault),
    .unfFlag  (underflowFault),
    .mmFlag   (mismatchFault),
    .violFlag (violPulse)
  );

  assign alert = overflowFault | underflowFault | mismatchFault;

endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtValid,
  input logic             evtKind,
  input logic [CNT_W-1:0] stackDepth,
  input logic             alert,
  input logic             overflowFault,
  input logic             underflowFault,
  input logic             mismatchFault,
  input logic             violPulse
);

  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= CNT_W'(DEPTH));

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtKind && stackDepth < CNT_W'(DEPTH))
      |=> stackDepth == CNT_W'($past(stackDepth) + CNT_W'(1)));

  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind && stackDepth != '0)
      |=> stackDepth == CNT_W'($past(stackDepth) - CNT_W'(1)));

  assert_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind && stackDepth == '0)
      |=> (underflowFault && stackDepth == '0));

  assert_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtKind && stackDepth == CNT_W'(DEPTH))
      |=> (overflowFault && stackDepth == CNT_W'(DEPTH)));

  assert_sticky_alert_R7: assert property (@(posedge clk) disable iff (!rstN)
    alert |=> alert);

  assert_sticky_mismatch_R7: assert property (@(posedge clk) disable iff (!rstN)
    mismatchFault |=> mismatchFault);

  assert_pulse_alert_R8: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> alert);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |=> ($stable(stackDepth) && !violPulse));

endmodule

bind scs_top scs_checker #(.DEPTH(DEPTH)) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .evtValid       (evtValid),
  .evtKind        (evtKind),
  .stackDepth     (stackDepth),
  .alert          (alert),
  .overflowFault  (overflowFault),
  .underflowFault (underflowFault),
  .mismatchFault  (mismatchFault),
  .violPulse      (violPulse)
);

// File: tb/scs_top_tb_top.sv
module scs_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DEPTH      = 32;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              evtValid = 1'b0;
  logic              evtKind = 1'b0;
  logic [ADDR_W-1:0] evtAddr = '0;
  logic [CNT_W-1:0]  stackDepth;
  logic              alert;
  logic              overflowFault;
  logic              underflowFault;
  logic              mismatchFault;
  logic              violPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scs_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .evtValid       (evtValid),
    .evtKind        (evtKind),
    .evtAddr        (evtAddr),
    .stackDepth     (stackDepth),
    .alert          (alert),
    .overflowFault  (overflowFault),
    .underflowFault (underflowFault),
    .mismatchFault  (mismatchFault),
    .violPulse      (violPulse)
  );

  function automatic logic [ADDR_W-1:0] addrOf(int idx, int salt);
    return 32'h0F00_0000 + ADDR_W'(idx) * 32'h104 + (ADDR_W'(salt) << 16);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at a falling edge; return at the next falling edge, after the sampling rise
  task automatic sendEv(bit kind, logic [ADDR_W-1:0] a);
    evtValid = 1'b1;
    evtKind  = kind;
    evtAddr  = a;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic doReset();
    evtValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkFlags(string req, int ovf, int unf, int mm);
    check(req, "overflowFault", overflowFault, ovf);
    check(req, "underflowFault", underflowFault, unf);
    check(req, "mismatchFault", mismatchFault, mm);
    check(req, "alert", alert, (ovf | unf | mm) != 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "stackDepth", stackDepth, 0);
    check("R1", "violPulse", violPulse, 0);
    checkFlags("R1", 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2, R10: back-to-back fill to the top
    for (int i = 0; i < DEPTH; i++) begin
      sendEv(1'b0, addrOf(i, 1));
      check("R2", "stackDepth during fill", stackDepth, i + 1);
    end
    check("R10", "violPulse after fill", violPulse, 0);

    // R9: inputs toggling with valid low change nothing
    for (int i = 0; i < 4; i++) begin
      evtKind = i[0];
      evtAddr = addrOf(i, 9);
      @(negedge clk);
      check("R9", "stackDepth idle", stackDepth, DEPTH);
      check("R9", "violPulse idle", violPulse, 0);
    end
    checkFlags("R9", 0, 0, 0);

    // R3: unwind with correct addresses
    for (int i = DEPTH - 1; i >= 0; i--) begin
      sendEv(1'b1, addrOf(i, 1));
      check("R3", "stackDepth during unwind", stackDepth, i);
      check("R3", "violPulse on good return", violPulse, 0);
    end
    checkFlags("R3", 0, 0, 0);

    // R5, R8: return on empty
    sendEv(1'b1, addrOf(0, 2));
    check("R5", "stackDepth after underflow", stackDepth, 0);
    check("R8", "violPulse after underflow", violPulse, 1);
    checkFlags("R5", 0, 1, 0);
    @(negedge clk);
    check("R8", "violPulse one cycle only", violPulse, 0);

    // R7: sticky through good traffic
    sendEv(1'b0, addrOf(3, 3));
    sendEv(1'b1, addrOf(3, 3));
    check("R7", "underflow held", underflowFault, 1);
    check("R7", "alert held", alert, 1);
    doReset();
    check("R7", "stackDepth after reset", stackDepth, 0);
    checkFlags("R7", 0, 0, 0);

    // R4: corrupted return at every depth; the pop still happens
    for (int d = 1; d <= DEPTH; d++) begin
      doReset();
      for (int i = 0; i < d; i++) sendEv(1'b0, addrOf(i, d));
      sendEv(1'b1, addrOf(d - 1, d) ^ 32'h0000_0010);
      check("R4", "stackDepth after mismatch", stackDepth, d - 1);
      check("R4", "violPulse on mismatch", violPulse, 1);
      checkFlags("R4", 0, 0, 1);
      if (d >= 2) begin
        sendEv(1'b1, addrOf(d - 2, d));
        check("R4", "next return compares entry below", violPulse, 0);
        check("R4", "stackDepth after next return", stackDepth, d - 2);
      end
    end

    // R6: overflow drops the address and keeps the stack intact
    doReset();
    for (int i = 0; i < DEPTH; i++) sendEv(1'b0, addrOf(i, 5));
    sendEv(1'b0, addrOf(77, 6));
    check("R6", "stackDepth after overflow", stackDepth, DEPTH);
    check("R8", "violPulse on overflow", violPulse, 1);
    checkFlags("R6", 1, 0, 0);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      sendEv(1'b1, addrOf(i, 5));
      check("R6", "held entry still matches", violPulse, 0);
    end
    check("R6", "stackDepth after unwind", stackDepth, 0);
    checkFlags("R6", 1, 0, 0);

    finishRun();
  end

endmodule